// File: doc/BRIEF.md
# Lock-aware PLL clock divider chain

This block is the digital divider and selection network placed around an analog PLL core. It picks the reference clock from either an internal trimmed clock (nominally 1 MHz) or an external oscillator. The oscillator path goes through a programmable reference divider. The VCO clock feeds a programmable post divider that produces the PLL clock. While the PLL reports no lock, that post divider is forced to a fixed divide-by-4. A final divide-by-2 stage makes the bus clock, either from the PLL clock or from the selected reference.

Every divider field is encoded as the ratio minus one. The block also reports the feedback multiplication ratio, 2 × (field + 1), for the analog loop to use. A new ratio or a lock change is applied only when the running period ends, so no output pulse is ever cut short. Odd ratios give a non-50 % duty cycle with an exact period, and a ratio of 1 passes the input clock straight through.

Top module: `pll_clkdiv_chain`

## Requirements
- R1: When `osc_en` is 1, `ref_clk` is derived from `osc_clk`. When it is 0, `ref_clk` is `irc_clk`. The selection is registered on `irc_clk`.
- R2: With the oscillator selected, one `ref_clk` period lasts `ref_div`+1 `osc_clk` periods, for every 4-bit value 0..15. A value of 0 passes `osc_clk` through.
- R3: `vco_mult` always equals 2 × (`syn_div`+1), so field values 0..63 map to 2..128.
- R4: While `pll_lock` is 1, one `pll_clk` period lasts `post_div`+1 `vco_clk` periods, for every 5-bit value 0..31.
- R5: While `pll_lock` is 0, one `pll_clk` period lasts 4 `vco_clk` periods, whatever `post_div` holds. `pll_lock` passes a two-stage synchronizer clocked by `vco_clk`.
- R6: When `pll_sel` is 1, `bus_clk` has twice the period of `pll_clk`.
- R7: When `pll_sel` is 0, `bus_clk` has twice the period of `ref_clk`.
- R8: A divider loads a new ratio only at its terminal count. Its counter never exceeds the ratio it is currently running.
- R9: While `rst_n` is 0, all divider counters are held clear and `bus_clk` does not toggle. The internal reference is selected and the PLL is deselected whatever `osc_en` and `pll_sel` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| irc_clk | input | 1 | Internal trimmed reference clock |
| osc_clk | input | 1 | External oscillator clock |
| vco_clk | input | 1 | VCO output clock from the analog core |
| rst_n | input | 1 | Synchronous active-low reset, sampled in each clock domain |
| pll_lock | input | 1 | Lock indication from the analog core (asynchronous) |
| osc_en | input | 1 | 1 selects the divided oscillator as the reference |
| pll_sel | input | 1 | 1 sources the bus clock from the PLL clock |
| ref_div | input | 4 | Reference divide ratio minus one |
| syn_div | input | 6 | Feedback multiplier field |
| post_div | input | 5 | Post divide ratio minus one |
| ref_clk | output | 1 | Selected and divided reference clock |
| pll_clk | output | 1 | Post-divided VCO clock |
| bus_clk | output | 1 | Bus clock, half the selected source frequency |
| vco_mult | output | 8 | Computed feedback ratio 2 × (syn_div+1) |

## Verification
The fallback ratio is the hardest case to reach from the ports. It is only visible while lock is low, and the lock level reaches the divider through a synchronizer and then waits for the end of the running period. The stimulus drops `pll_lock` while a large `post_div` is programmed and skips several output periods before timing one. It then checks that the measured period stays at four VCO cycles for small, mid-range and maximum `post_div` values. Afterwards it raises lock again and confirms that the programmed ratio returns.

// File: rtl/pll_clkdiv_pkg.sv
// Package: field widths and fixed constants shared by the divider chain.
package pll_clkdiv_pkg;
    localparam int REF_DIV_W   = 4;   // reference divide field width
    localparam int SYN_DIV_W   = 6;   // multiplier field width
    localparam int POST_DIV_W  = 5;   // post divide field width
    localparam int FALLBACK_M1 = 3;   // divide-by-4 while unlocked, minus one

    // Feedback multiplication ratio for a multiplier field value.
    function automatic logic [SYN_DIV_W+1:0] mult_ratio(input logic [SYN_DIV_W-1:0] f);
        return ({2'b00, f} + 1'b1) << 1;
    endfunction
endpackage

// File: rtl/clkdiv_core.sv
// Module: clkdiv_core
// Integer clock divider of ratio (ratio_m1 + 1).
// - The output is high for floor(N/2) input cycles and low for the rest, so
//   odd ratios keep an exact period with an uneven duty cycle.
// - A ratio of 1 bypasses the counter and forwards clk_in.
// - ratio_m1 is sampled only at the terminal count, so no pulse is cut short.
// Assumes: rst_n is held low for at least one clk_in edge.
module clkdiv_core #(
    parameter int W = 4
) (
    input  logic         clk_in,
    input  logic         rst_n,
    input  logic [W-1:0] ratio_m1,
    output logic         clk_out,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] act_o
);
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] act_q, act_d;
    logic [W:0]   half_d;
    logic         phase_q;

    // Next count and ratio: wrap and reload at the terminal count.
    always_comb begin
        if (cnt_q == act_q) begin
            cnt_d = '0;
            act_d = ratio_m1;
        end else begin
            cnt_d = cnt_q + 1'b1;
            act_d = act_q;
        end
        half_d = ({1'b0, act_d} + 1'b1) >> 1;
    end

    // Counter, active ratio and output phase registers.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            act_q   <= ratio_m1;
            phase_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            act_q   <= act_d;
            phase_q <= ({1'b0, cnt_d} < half_d);
        end
    end

    assign clk_out = (act_q == '0) ? clk_in : phase_q;
    assign cnt_o   = cnt_q;
    assign act_o   = act_q;
endmodule

// File: rtl/lock_sync.sv
// Module: lock_sync
// Two-stage synchronizer that brings the asynchronous lock flag into the
// VCO domain. Assumes: the lock flag changes slowly compared with clk.
module lock_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta_q, sync_q;

    // Shift the flag through two flops; reset reads as unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/bus_toggle.sv
// Module: bus_toggle
// Divide-by-2 toggle stage for the bus clock. Assumes: clk_in keeps
// running during reset so that the synchronous reset takes effect.
module bus_toggle (
    input  logic clk_in,
    input  logic rst_n,
    output logic clk_out
);
    logic tog_q;

    // Toggle on every source edge; hold low in reset.
    always_ff @(posedge clk_in) begin
        if (!rst_n) tog_q <= 1'b0;
        else        tog_q <= ~tog_q;
    end

    assign clk_out = tog_q;
endmodule

// File: rtl/pll_clkdiv_chain.sv
// Module: pll_clkdiv_chain (top)
// Reference selection, reference divider, lock-aware post divider and bus
// clock stage around an analog PLL core.
// Assumes: irc_clk always runs; the select inputs are quasi-static, because
// the clock multiplexers are plain multiplexers, not glitch-free switches.
module pll_clkdiv_chain
    import pll_clkdiv_pkg::*;
#(
    parameter int REF_W  = REF_DIV_W,
    parameter int SYN_W  = SYN_DIV_W,
    parameter int POST_W = POST_DIV_W
) (
    input  logic              irc_clk,
    input  logic              osc_clk,
    input  logic              vco_clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              osc_en,
    input  logic              pll_sel,
    input  logic [REF_W-1:0]  ref_div,
    input  logic [SYN_W-1:0]  syn_div,
    input  logic [POST_W-1:0] post_div,
    output logic              ref_clk,
    output logic              pll_clk,
    output logic              bus_clk,
    output logic [SYN_W+1:0]  vco_mult
);
    localparam logic [POST_W-1:0] FB_M1 = POST_W'(FALLBACK_M1);

    logic              osc_sel_q, pll_sel_q;
    logic              osc_div_clk, lock_s, bus_src;
    logic [REF_W-1:0]  ref_cnt, ref_act;
    logic [POST_W-1:0] post_cnt, post_act, post_eff;

    // Register the source selects in the always-running internal domain.
    always_ff @(posedge irc_clk) begin
        if (!rst_n) begin
            osc_sel_q <= 1'b0;
            pll_sel_q <= 1'b0;
        end else begin
            osc_sel_q <= osc_en;
            pll_sel_q <= pll_sel;
        end
    end

    clkdiv_core #(.W(REF_W)) u_ref_div (
        .clk_in(osc_clk), .rst_n(rst_n), .ratio_m1(ref_div),
        .clk_out(osc_div_clk), .cnt_o(ref_cnt), .act_o(ref_act)
    );

    assign ref_clk = osc_sel_q ? osc_div_clk : irc_clk;

    lock_sync u_lock_sync (
        .clk(vco_clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s)
    );

    // Post ratio: programmed value when locked, fixed fallback otherwise.
    always_comb post_eff = lock_s ? post_div : FB_M1;

    clkdiv_core #(.W(POST_W)) u_post_div (
        .clk_in(vco_clk), .rst_n(rst_n), .ratio_m1(post_eff),
        .clk_out(pll_clk), .cnt_o(post_cnt), .act_o(post_act)
    );

    assign bus_src = pll_sel_q ? pll_clk : ref_clk;

    bus_toggle u_bus (
        .clk_in(bus_src), .rst_n(rst_n), .clk_out(bus_clk)
    );

    assign vco_mult = mult_ratio(syn_div);
endmodule

// File: rtl/pll_clkdiv_chain_chk.sv
// Module: pll_clkdiv_chain_chk
// Property checker attached to pll_clkdiv_chain by bind.
module pll_clkdiv_chain_chk #(
    parameter int REF_W  = 4,
    parameter int POST_W = 5
) (
    input logic              vco_clk,
    input logic              osc_clk,
    input logic              bus_src,
    input logic              rst_n,
    input logic              lock_s,
    input logic              bus_clk,
    input logic [POST_W-1:0] post_div,
    input logic [POST_W-1:0] post_cnt,
    input logic [POST_W-1:0] post_act,
    input logic [REF_W-1:0]  ref_cnt,
    input logic [REF_W-1:0]  ref_act
);
    AST_FALLBACK_LOAD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (post_cnt == post_act && !lock_s) |=> (post_act == POST_W'(3))); // R5

    AST_LOCKED_LOAD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (post_cnt == post_act && lock_s) |=> (post_act == $past(post_div))); // R4

    AST_POST_RATIO_HOLD: assert property (@(posedge vco_clk) disable iff (!rst_n)
        (post_cnt != post_act) |=> $stable(post_act)); // R8

    AST_POST_CNT_BOUND: assert property (@(posedge vco_clk) disable iff (!rst_n)
        post_cnt <= post_act); // R8

    AST_REF_RATIO_HOLD: assert property (@(posedge osc_clk) disable iff (!rst_n)
        (ref_cnt != ref_act) |=> $stable(ref_act)); // R8

    AST_BUS_TOGGLE: assert property (@(posedge bus_src) disable iff (!rst_n)
        rst_n |=> (bus_clk != $past(bus_clk))); // R6
endmodule

bind pll_clkdiv_chain pll_clkdiv_chain_chk #(.REF_W(REF_W), .POST_W(POST_W)) u_chk (
    .vco_clk(vco_clk), .osc_clk(osc_clk), .bus_src(bus_src), .rst_n(rst_n),
    .lock_s(lock_s), .bus_clk(bus_clk), .post_div(post_div),
    .post_cnt(post_cnt), .post_act(post_act),
    .ref_cnt(ref_cnt), .ref_act(ref_act)
);

// File: tb/sim_pll_clkdiv_chain.sv
`timescale 1ns/1ps
module sim_pll_clkdiv_chain;
    localparam int CLK_PERIOD = 10;  // internal reference clock period (ns)
    localparam int OSC_PERIOD = 6;
    localparam int VCO_PERIOD = 2;

    logic irc_clk = 0, osc_clk = 0, vco_clk = 0;
    logic rst_n = 0, pll_lock = 0, osc_en = 0, pll_sel = 0;
    logic [3:0] ref_div = 0;
    logic [5:0] syn_div = 0;
    logic [4:0] post_div = 0;
    logic ref_clk, pll_clk, bus_clk;
    logic [7:0] vco_mult;

    always #(CLK_PERIOD/2.0) irc_clk = ~irc_clk;
    always #(OSC_PERIOD/2.0) osc_clk = ~osc_clk;
    always #(VCO_PERIOD/2.0) vco_clk = ~vco_clk;

    pll_clkdiv_chain u0 (
        .irc_clk(irc_clk), .osc_clk(osc_clk), .vco_clk(vco_clk), .rst_n(rst_n),
        .pll_lock(pll_lock), .osc_en(osc_en), .pll_sel(pll_sel),
        .ref_div(ref_div), .syn_div(syn_div), .post_div(post_div),
        .ref_clk(ref_clk), .pll_clk(pll_clk), .bus_clk(bus_clk), .vco_mult(vco_mult)
    );

    typedef struct {
        int    which;   // 0 ref_clk, 1 pll_clk, 2 bus_clk
        int    exp_ns;
        string req;
    } item_t;

    item_t q[$];
    int checks = 0, fails = 0, issued = 0, done_cnt = 0, bus_edges = 0;
    bit finished = 0;

    always @(posedge bus_clk) bus_edges++;

    task automatic wait_edge(input int which);
        case (which)
            0:       @(posedge ref_clk);
            1:       @(posedge pll_clk);
            default: @(posedge bus_clk);
        endcase
    endtask

    // Monitor: pop each expectation, skip settling edges, time one period.
    initial begin
        forever begin
            item_t it;
            realtime t1, t2;
            int got;
            wait (q.size() > 0);
            it = q.pop_front();
            repeat (4) wait_edge(it.which);
            t1 = $realtime;
            wait_edge(it.which);
            t2 = $realtime;
            got = $rtoi(t2 - t1 + 0.5);
            checks++;
            if (got != it.exp_ns) begin
                fails++;
                $display("FAIL %s: output %0d period %0d ns, expected %0d ns",
                         it.req, it.which, got, it.exp_ns);
            end
            done_cnt++;
        end
    end

    // Driver: push one expected period and wait until it is scored.
    task automatic expect_period(input int which, input int exp_ns, input string req);
        item_t it;
        it.which = which; it.exp_ns = exp_ns; it.req = req;
        issued++;
        q.push_back(it);
        wait (done_cnt == issued);
    endtask

    task automatic check_mult(input int f);
        syn_div = 6'(f);
        #1;
        checks++;
        if (vco_mult != 8'(2 * (f + 1))) begin
            fails++;
            $display("FAIL R3: vco_mult %0d, expected %0d", vco_mult, 2 * (f + 1));
        end
    endtask

    initial begin
        int b0;
        // R9: reset selects the internal clock even with osc_en high.
        osc_en = 1; pll_sel = 1; ref_div = 4'd2;
        repeat (3) @(negedge irc_clk);
        expect_period(0, CLK_PERIOD, "R9");
        b0 = bus_edges;
        #(20 * CLK_PERIOD);
        checks++;
        if (bus_edges != b0) begin
            fails++;
            $display("FAIL R9: bus_clk edges in reset %0d, expected 0", bus_edges - b0);
        end
        osc_en = 0; pll_sel = 0; ref_div = 0;
        @(negedge irc_clk);
        rst_n = 1;
        repeat (4) @(negedge irc_clk);

        // R1 / R7: internal reference and bus derived from it.
        expect_period(0, CLK_PERIOD, "R1");
        expect_period(2, 2 * CLK_PERIOD, "R7");

        // R1 / R2 / R8: oscillator path over every reference ratio.
        osc_en = 1;
        repeat (4) @(negedge irc_clk);
        for (int r = 0; r < 16; r++) begin
            ref_div = 4'(r);
            expect_period(0, OSC_PERIOD * (r + 1), "R2");
        end
        ref_div = 4'd3;
        expect_period(2, 2 * OSC_PERIOD * 4, "R7");

        // R4 / R8: locked post divider over every ratio.
        pll_lock = 1;
        repeat (4) @(negedge vco_clk);
        for (int p = 0; p < 32; p++) begin
            post_div = 5'(p);
            expect_period(1, VCO_PERIOD * (p + 1), "R4");
        end

        // R6: bus from the PLL clock.
        post_div = 5'd4;
        pll_sel = 1;
        repeat (4) @(negedge irc_clk);
        expect_period(2, 2 * VCO_PERIOD * 5, "R6");

        // R5: fallback divide-by-4 while unlocked, then recovery.
        post_div = 5'd31;
        expect_period(1, VCO_PERIOD * 32, "R4");
        pll_lock = 0;
        expect_period(1, VCO_PERIOD * 4, "R5");
        post_div = 5'd0;
        expect_period(1, VCO_PERIOD * 4, "R5");
        post_div = 5'd7;
        expect_period(1, VCO_PERIOD * 4, "R5");
        expect_period(2, 2 * VCO_PERIOD * 4, "R6");
        pll_lock = 1;
        post_div = 5'd5;
        expect_period(1, VCO_PERIOD * 6, "R5");

        // R3: multiplier ratio at the ends and middle of the field.
        check_mult(0);
        check_mult(31);
        check_mult(63);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule